// File: doc/BRIEF.md
# Converter Power-State Sequencer

This block is the operating-mode state machine at the top of a switching-converter controller. It takes digitised, clock-synchronous comparator flags as inputs. Two flags watch the bias supply: one shows it has reached its turn-on level, the other shows it is still above its turn-off level. Three flags watch a scaled copy of the input line: above a reset level, above a standby level, and above an enable level. The last input is a pulse-inhibit request from the fault manager. From these inputs the block chooses one of four modes: shutdown, standby, running or fault-hold. It drives the switching enable, the enable of the line-hysteresis current source and the discharge command for the soft-start capacitor.

Two detectors qualify the line flags. The standby detector needs about 5 µs of steady input and the enable detector needs about 1 µs. Either detector restarts from zero if its flag drops before the window ends. The time since the supply reached its turn-on level is counted separately. The soft-start is not released until about 25 µs have passed. A supply drop or a line reset sends every mode back to shutdown. Losing only the enable level takes the block back to standby. A fault request parks the block in fault-hold. When the request clears, the block returns to running through a soft-start discharge step.

Top module: `conv_mode_seq`

## Requirements
- R1: While reset is held and right after it is released, the mode code is 0 (shutdown), `sw_en_o` is 0, `hys_src_o` is 0 and `ss_dis_o` is 1.
- R2: Shutdown moves to standby (code 1) only after `line_stby_i` has been high for STBY_CYC consecutive cycles (250 at the defaults) while `vcc_ok_i` and `line_rst_i` are high. A low cycle restarts the count. No other mode follows shutdown.
- R3: Switching starts only after `line_enl_i` has been high for EN_CYC consecutive cycles (50 at the defaults). A low cycle restarts that count.
- R4: Switching starts only once `vcc_on_i` has been seen, and only when at least DLY_CYC cycles (1250 at the defaults) have passed since then.
- R5: `hys_src_o` rises at least one cycle before `sw_en_o` rises, and it stays high in the running and fault-hold modes.
- R6: `ss_dis_o` is high in every mode except running, and low in running.
- R7: If `vcc_ok_i` or `line_rst_i` is low, the next mode is shutdown with all drive outputs off, from any mode. A supply drop also clears the turn-on record, so a new `vcc_on_i` and a new full delay are needed.
- R8: In running, a low `line_enl_i` returns the block to standby, not to shutdown, with `sw_en_o` low. Switching resumes after the enable detector qualifies again.
- R9: In running, a high `flt_i` moves the block to fault-hold (code 3) on the next cycle with `sw_en_o` low. Once `flt_i` clears, the block passes through standby with the soft-start discharged and then runs again.
- R10: The mode code is 0 for shutdown, 1 for standby, 2 for running and 3 for fault-hold. `sw_en_o` is high exactly when the code is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_on_i | input | 1 | Supply has reached its turn-on level |
| vcc_ok_i | input | 1 | Supply is above its turn-off level |
| line_rst_i | input | 1 | Line sense is above the reset level |
| line_stby_i | input | 1 | Line sense is above the standby level |
| line_enl_i | input | 1 | Line sense is above the enable level (hysteresis applied outside) |
| flt_i | input | 1 | Pulse-inhibit request from the fault manager |
| state_o | output | 2 | Mode code (see R10) |
| sw_en_o | output | 1 | Switching enable |
| hys_src_o | output | 1 | Line-hysteresis current source enable |
| ss_dis_o | output | 1 | Soft-start capacitor discharge command |

## Verification
The properties assume that all inputs are already synchronous to `clk` and change only between edges. They also assume the line flags stay nested, so that enable implies standby and standby implies above-reset, as they do when they come from one divided voltage. The bench changes every input at falling edges and keeps this nesting. When it drops the line, it clears the upper flags together with or before the lower ones. Fault requests are raised only while the block is running or in standby.

// File: rtl/conv_mode_pkg.sv
// Shared mode encoding for the converter power-state sequencer.
// Assumes: the code values are decoded by neighbouring blocks, so they stay fixed.
package conv_mode_pkg;
    typedef enum logic [1:0] {
        MS_SHUT = 2'd0,
        MS_STBY = 2'd1,
        MS_RUN  = 2'd2,
        MS_HOLD = 2'd3
    } mode_t;
endpackage

// File: rtl/conv_mode_filt.sv
// Consecutive-cycle qualifier: q_o rises once in_i has been high for CYC
// sampled edges in a row. It falls on the edge after in_i is seen low.
// Assumes: in_i is synchronous to clk; CYC >= 2.
module conv_mode_filt #(
    parameter int CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic q_o
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    // Count steady-high cycles; any low cycle restarts the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_i) begin
            cnt <= '0;
            q_o <= 1'b0;
        end else if (cnt == LAST) begin
            q_o <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/conv_mode_dly.sv
// Supply turn-on record and start-up delay timer. ready_o latches when the
// supply reaches turn-on. done_o rises DLY cycles later and is sticky until
// the supply drops below its turn-off level.
// Assumes: vcc_on_i implies vcc_ok_i; DLY >= 2.
module conv_mode_dly #(
    parameter int DLY = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_on_i,
    input  logic vcc_ok_i,
    output logic ready_o,
    output logic done_o
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt;

    // Latch the turn-on event; clear it on any supply drop.
    always_ff @(posedge clk) begin
        if (!rst_n || !vcc_ok_i) ready_o <= 1'b0;
        else if (vcc_on_i)       ready_o <= 1'b1;
    end

    // Run the release delay once the turn-on event is recorded.
    always_ff @(posedge clk) begin
        if (!rst_n || !vcc_ok_i) begin
            cnt    <= '0;
            done_o <= 1'b0;
        end else if (ready_o && !done_o) begin
            if (cnt == LAST) done_o <= 1'b1;
            else             cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/conv_mode_fsm.sv
// Mode state machine: shutdown, standby, running, fault-hold. A drop request
// (supply or line reset) wins over everything, then fault, then enable loss.
// The hysteresis source arms one cycle before running is entered.
// Assumes: the qualified inputs come from conv_mode_filt / conv_mode_dly.
module conv_mode_fsm
    import conv_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stby_q_i,
    input  logic  en_q_i,
    input  logic  vcc_ok_i,
    input  logic  line_rst_i,
    input  logic  ready_i,
    input  logic  done_i,
    input  logic  flt_i,
    output mode_t mode_o,
    output logic  hys_o,
    output logic  sw_en_o,
    output logic  ss_dis_o
);
    mode_t mode_q, mode_d;
    logic  drop;
    logic  arm;
    logic  arm_q;

    assign drop = !vcc_ok_i || !line_rst_i;
    assign arm  = (mode_q == MS_STBY) && ready_i && done_i && en_q_i && !flt_i && !drop;

    // Next-mode selection by priority: drop, fault, enable loss.
    always_comb begin
        mode_d = mode_q;
        if (drop) begin
            mode_d = MS_SHUT;
        end else begin
            unique case (mode_q)
                MS_SHUT: if (stby_q_i)      mode_d = MS_STBY;
                MS_STBY: if (arm && arm_q)  mode_d = MS_RUN;
                MS_RUN: begin
                    if (flt_i)              mode_d = MS_HOLD;
                    else if (!en_q_i)       mode_d = MS_STBY;
                end
                MS_HOLD: if (!flt_i)        mode_d = MS_STBY;
                default:                    mode_d = MS_SHUT;
            endcase
        end
    end

    // Mode register and one-cycle arm history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MS_SHUT;
            arm_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            arm_q  <= arm;
        end
    end

    // Output decode from the mode register.
    always_comb begin
        mode_o   = mode_q;
        sw_en_o  = (mode_q == MS_RUN);
        ss_dis_o = (mode_q != MS_RUN);
        hys_o    = (mode_q == MS_RUN) || (mode_q == MS_HOLD) || ((mode_q == MS_STBY) && arm_q);
    end
endmodule

// File: rtl/conv_mode_seq.sv
// Top of the converter power-state sequencer. It converts the filter and
// delay times into cycle counts from CLK_HZ and wires the qualifiers to the
// mode machine.
// Assumes: all inputs are synchronous to clk; the line flags are nested.
module conv_mode_seq
    import conv_mode_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int STBY_NS   = 5_000,
    parameter int EN_NS     = 1_000,
    parameter int SS_DLY_NS = 25_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_on_i,
    input  logic       vcc_ok_i,
    input  logic       line_rst_i,
    input  logic       line_stby_i,
    input  logic       line_enl_i,
    input  logic       flt_i,
    output logic [1:0] state_o,
    output logic       sw_en_o,
    output logic       hys_src_o,
    output logic       ss_dis_o
);
    localparam int KHZ      = CLK_HZ / 1000;
    localparam int STBY_CYC = (KHZ * STBY_NS) / 1_000_000;
    localparam int EN_CYC   = (KHZ * EN_NS) / 1_000_000;
    localparam int DLY_CYC  = (KHZ * SS_DLY_NS) / 1_000_000;

    logic  stby_q, en_q, ready, done;
    mode_t mode;

    conv_mode_filt #(.CYC(STBY_CYC)) u_stby_filt (
        .clk(clk), .rst_n(rst_n), .in_i(line_stby_i), .q_o(stby_q)
    );

    conv_mode_filt #(.CYC(EN_CYC)) u_en_filt (
        .clk(clk), .rst_n(rst_n), .in_i(line_enl_i), .q_o(en_q)
    );

    conv_mode_dly #(.DLY(DLY_CYC)) u_dly (
        .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on_i), .vcc_ok_i(vcc_ok_i),
        .ready_o(ready), .done_o(done)
    );

    conv_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .stby_q_i(stby_q), .en_q_i(en_q),
        .vcc_ok_i(vcc_ok_i), .line_rst_i(line_rst_i), .ready_i(ready),
        .done_i(done), .flt_i(flt_i), .mode_o(mode), .hys_o(hys_src_o),
        .sw_en_o(sw_en_o), .ss_dis_o(ss_dis_o)
    );

    assign state_o = mode;
endmodule

// File: rtl/conv_mode_seq_chk.sv
// Property checker for conv_mode_seq, attached through bind.
// Assumes: inputs are synchronous and the line flags are nested.
module conv_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_ok_i,
    input logic       line_rst_i,
    input logic       flt_i,
    input logic [1:0] state_o,
    input logic       sw_en_o,
    input logic       hys_src_o,
    input logic       ss_dis_o
);
    AST_DROP_TO_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_ok_i || !line_rst_i) |=> (state_o == 2'd0 && !sw_en_o && !hys_src_o)); // R7

    AST_HYS_BEFORE_SW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en_o) |-> $past(hys_src_o)); // R5

    AST_SS_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en_o |-> ss_dis_o); // R6

    AST_SHUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |=> (state_o == 2'd0 || state_o == 2'd1)); // R2

    AST_FLT_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && flt_i && vcc_ok_i && line_rst_i) |=> (state_o == 2'd3 && !sw_en_o)); // R9

    AST_CODE_SW: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en_o == (state_o == 2'd2)); // R10
endmodule

bind conv_mode_seq conv_mode_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .vcc_ok_i(vcc_ok_i), .line_rst_i(line_rst_i),
    .flt_i(flt_i), .state_o(state_o), .sw_en_o(sw_en_o),
    .hys_src_o(hys_src_o), .ss_dis_o(ss_dis_o)
);

// File: tb/conv_mode_seq_bench.sv
// Directed bench for conv_mode_seq: one task per scenario, each checking itself.
module conv_mode_seq_bench;
    localparam int STBY_CYC = 250;
    localparam int EN_CYC   = 50;
    localparam int DLY_CYC  = 1250;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       vcc_on_i, vcc_ok_i, line_rst_i, line_stby_i, line_enl_i, flt_i;
    logic [1:0] state_o;
    logic       sw_en_o, hys_src_o, ss_dis_o;

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;

    always #10 clk = ~clk;

    conv_mode_seq u_conv_mode_seq (
        .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on_i), .vcc_ok_i(vcc_ok_i),
        .line_rst_i(line_rst_i), .line_stby_i(line_stby_i), .line_enl_i(line_enl_i),
        .flt_i(flt_i), .state_o(state_o), .sw_en_o(sw_en_o),
        .hys_src_o(hys_src_o), .ss_dis_o(ss_dis_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; vcc_on_i = 0; vcc_ok_i = 0; line_rst_i = 0;
        line_stby_i = 0; line_enl_i = 0; flt_i = 0;
        step(5);
        chk("R1 code in reset", state_o, 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 code after reset", state_o, 0);
        chk("R1 sw_en", sw_en_o, 0);
        chk("R1 hys", hys_src_o, 0);
        chk("R1 ss_dis", ss_dis_o, 1);
    endtask

    task automatic t_stby_filter();
        vcc_ok_i = 1; line_rst_i = 1;
        line_stby_i = 1; step(STBY_CYC - 5);
        line_stby_i = 0; step(1);
        line_stby_i = 1; step(STBY_CYC - 5);
        chk("R2 restart keeps shutdown", state_o, 0);
        step(20);
        chk("R2 standby after window", state_o, 1);
        chk("R6 ss_dis in standby", ss_dis_o, 1);
    endtask

    task automatic t_startup();
        int hys_at = -1;
        int sw_at  = -1;
        line_enl_i = 1;
        step(100);
        chk("R4 no switching without supply", sw_en_o, 0);
        chk("R4 still standby", state_o, 1);
        vcc_on_i = 1;
        for (int i = 0; i < DLY_CYC + 200; i++) begin
            step(1);
            if (hys_src_o && hys_at < 0) hys_at = i;
            if (sw_en_o && sw_at < 0)    sw_at = i;
        end
        chk("R4 switching started", int'(sw_at >= 0), 1);
        chk("R4 delay respected", int'(sw_at >= DLY_CYC), 1);
        chk("R5 hys before switching", int'(hys_at >= 0 && hys_at < sw_at), 1);
        chk("R10 running code", state_o, 2);
        chk("R6 ss_dis released", ss_dis_o, 0);
    endtask

    task automatic t_line_enable();
        line_enl_i = 0; step(5);
        chk("R8 back to standby", state_o, 1);
        chk("R8 switching off", sw_en_o, 0);
        chk("R6 ss_dis in standby", ss_dis_o, 1);
        line_enl_i = 1; step(EN_CYC - 5);
        line_enl_i = 0; step(1);
        line_enl_i = 1; step(EN_CYC - 5);
        chk("R3 restart blocks switching", sw_en_o, 0);
        step(20);
        chk("R3 running after window", state_o, 2);
        chk("R8 switching resumed", sw_en_o, 1);
    endtask

    task automatic t_fault();
        flt_i = 1; step(3);
        chk("R9 fault-hold code", state_o, 3);
        chk("R9 switching off", sw_en_o, 0);
        chk("R5 hys kept in hold", hys_src_o, 1);
        chk("R6 ss_dis in hold", ss_dis_o, 1);
        flt_i = 0; step(1);
        chk("R9 discharge step via standby", state_o, 1);
        step(6);
        chk("R9 running again", state_o, 2);
    endtask

    task automatic t_line_reset();
        line_enl_i = 0; line_stby_i = 0; line_rst_i = 0; step(2);
        chk("R7 line reset to shutdown", state_o, 0);
        chk("R7 hys off", hys_src_o, 0);
        line_rst_i = 1; line_stby_i = 1; line_enl_i = 1;
        step(STBY_CYC + EN_CYC + 40);
        chk("R7 recovers from line reset", int'(state_o != 0), 1);
    endtask

    task automatic t_supply_drop();
        vcc_ok_i = 0; vcc_on_i = 0; step(2);
        chk("R7 supply drop to shutdown", state_o, 0);
        chk("R7 switching off", sw_en_o, 0);
        vcc_ok_i = 1;
        step(STBY_CYC + EN_CYC + 50);
        chk("R7 needs new turn-on", sw_en_o, 0);
        vcc_on_i = 1;
        step(DLY_CYC - 20);
        chk("R4 new delay enforced", sw_en_o, 0);
        step(80);
        chk("R4 running after new delay", state_o, 2);
    endtask

    initial begin
        t_reset();
        t_stby_filter();
        t_startup();
        t_line_enable();
        t_fault();
        t_line_reset();
        t_supply_drop();
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule